// File: doc/BRIEF.md
# Configurable-Granularity FIFO Address Counter

This block produces the read and write pointers of a FIFO built from one or more stacked RAM blocks. A width mode sets how wide one data word is, and so which counter bit is the lowest in use. Every accepted access adds one word at that bit. A cascade mode sets how many bits above the in-block address are in use. Those bits choose among the stacked RAM blocks. Bits outside the active range stay at zero, so the same 16-bit pointer works for every shape.

Each pointer is split into two parts. The lower twelve bits form a location inside a RAM block. The upper four bits are decoded into a one-hot enable for the selected block. Full and empty come from outside and gate writes and reads. Both mode inputs are captured only while reset is held, so a new shape needs a reset.

Top module: `fifo_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both counters become 0x0000 after that edge. Both block enables then read 0x0001.
- R2: `wid_mode` sets the write step: 0 gives 32, 1 gives 16, 2 gives 8, 3 gives 4, 4 gives 2, and 5, 6 and 7 give 1. This corresponds to word widths of 36, 18, 9, 4, 2 and 1 bits.
- R3: The read counter uses the same step as the write counter and advances by it on each accepted read.
- R4: A write request made while `wr_full` is high leaves `wr_cnt` unchanged. A read request made while `rd_empty` is high leaves `rd_cnt` unchanged.
- R5: `cas_mode` sets the top active bit: 0 gives bit 11, 1 gives bit 12, 2 gives bit 13, 3 gives bit 14, and 4 to 7 give bit 15. A step that carries out of the top active bit wraps the counter to zero.
- R6: Counter bits below the lowest active bit and above the top active bit are always zero.
- R7: The mode inputs are sampled only in cycles where `rst` is high. A change made while reset is low has no effect until the next reset.
- R8: `*_loc` equals counter bits 11:0. `*_blk_en` is one-hot, with bit k set when counter bits 15:12 equal k.
- R9: A write and a read accepted in the same cycle each advance their own counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also loads the mode inputs |
| wid_mode | input | 3 | Word width selection (step size) |
| cas_mode | input | 3 | Number of stacked blocks (top active bit) |
| wr_req | input | 1 | Write access request |
| wr_full | input | 1 | FIFO full; blocks writes |
| rd_req | input | 1 | Read access request |
| rd_empty | input | 1 | FIFO empty; blocks reads |
| wr_cnt | output | 16 | Write counter |
| rd_cnt | output | 16 | Read counter |
| wr_loc | output | 12 | Write location inside a block |
| rd_loc | output | 12 | Read location inside a block |
| wr_blk_en | output | 16 | One-hot write block enable |
| rd_blk_en | output | 16 | One-hot read block enable |

## Verification
The assertions check four things on every cycle:
- inactive counter bits stay zero;
- a blocked or absent request holds the counter;
- an accepted access always moves the counter;
- the block enable stays one-hot.

The exact step for each width mode can only be shown by the bench's scenarios, as can the wrap point for each cascade depth. The same holds for mode changes being ignored without a reset and for the block enable following the upper bits across a block boundary.

// File: rtl/fifo_addr_pkg.sv
package fifo_addr_pkg;
  localparam int PTR_W   = 16;
  localparam int LOC_W   = 12;
  localparam int LO_MAX  = 5;   // lowest active bit for the widest word
  localparam int MODE_W  = 3;

  // lowest active bit for a width mode; codes above LO_MAX mean 1-bit words
  function automatic int unsigned step_bit(input logic [MODE_W-1:0] wm);
    if (int'(wm) >= LO_MAX) return 0;
    return LO_MAX - int'(wm);
  endfunction

  // highest active bit for a cascade mode, capped at the pointer width
  function automatic int unsigned top_bit(input logic [MODE_W-1:0] cm,
                                          input int unsigned loc_w,
                                          input int unsigned ptr_w);
    int unsigned t;
    t = loc_w - 1 + int'(cm);
    if (t > ptr_w - 1) t = ptr_w - 1;
    return t;
  endfunction

  function automatic logic [PTR_W-1:0] span_mask(input int unsigned lo,
                                                 input int unsigned hi);
    logic [PTR_W-1:0] m;
    for (int b = 0; b < PTR_W; b++) m[b] = (b >= int'(lo)) && (b <= int'(hi));
    return m;
  endfunction
endpackage

// File: rtl/fifo_addr_cfg.sv
module fifo_addr_cfg
  import fifo_addr_pkg::*;
#(
  parameter int CNT_W = PTR_W,
  parameter int ADR_W = LOC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] wid_mode,
  input  logic [MODE_W-1:0] cas_mode,
  output logic [CNT_W-1:0]  step,
  output logic [CNT_W-1:0]  mask
);
  logic [MODE_W-1:0] wid_q, cas_q;

  // modes are captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      wid_q <= wid_mode;
      cas_q <= cas_mode;
    end
  end

  logic [PTR_W-1:0] mask_full;
  assign mask_full = span_mask(step_bit(wid_q), top_bit(cas_q, ADR_W, CNT_W));
  assign mask      = mask_full[CNT_W-1:0];
  assign step      = CNT_W'(1) << step_bit(wid_q);

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(step) && $stable(mask));
endmodule

// File: rtl/fifo_addr_ctr.sv
module fifo_addr_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [CNT_W-1:0] step,
  input  logic [CNT_W-1:0] mask,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_nxt;

  // masking drops the carry out of the top active bit, so the field wraps
  assign cnt_nxt = (cnt + step) & mask;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt_nxt;
  end

  // R6
  inactive_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt & ~mask) == '0);
  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> cnt != $past(cnt));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/fifo_blk_decode.sv
module fifo_blk_decode #(
  parameter int CNT_W = 16,
  parameter int ADR_W = 12,
  localparam int SEL_W = CNT_W - ADR_W,
  localparam int NBLK  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  output logic [ADR_W-1:0] loc,
  output logic [NBLK-1:0]  blk_en
);
  logic [SEL_W-1:0] sel;
  assign sel = cnt[CNT_W-1:ADR_W];
  assign loc = cnt[ADR_W-1:0];

  for (genvar k = 0; k < NBLK; k++) begin : g_en
    assign blk_en[k] = (sel == SEL_W'(k));
  end

  // R8
  blk_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(blk_en) == 1);
endmodule

// File: rtl/fifo_addr_gen.sv
module fifo_addr_gen
  import fifo_addr_pkg::*;
#(
  parameter int CNT_W = PTR_W,
  parameter int ADR_W = LOC_W,
  localparam int NBLK = 1 << (CNT_W - ADR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] wid_mode,
  input  logic [MODE_W-1:0] cas_mode,
  input  logic              wr_req,
  input  logic              wr_full,
  input  logic              rd_req,
  input  logic              rd_empty,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [ADR_W-1:0]  wr_loc,
  output logic [ADR_W-1:0]  rd_loc,
  output logic [NBLK-1:0]   wr_blk_en,
  output logic [NBLK-1:0]   rd_blk_en
);
  logic [CNT_W-1:0] step, mask;

  fifo_addr_cfg #(.CNT_W(CNT_W), .ADR_W(ADR_W)) u_cfg (
    .clk, .rst, .wid_mode, .cas_mode, .step, .mask
  );

  // channel 0 = write, channel 1 = read
  logic [1:0]                  acc;
  logic [1:0][CNT_W-1:0]       cnt;
  logic [1:0][ADR_W-1:0]       loc;
  logic [1:0][NBLK-1:0]        blk;

  assign acc[0] = wr_req && !wr_full;
  assign acc[1] = rd_req && !rd_empty;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    fifo_addr_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk, .rst, .inc(acc[c]), .step, .mask, .cnt(cnt[c])
    );
    fifo_blk_decode #(.CNT_W(CNT_W), .ADR_W(ADR_W)) u_dec (
      .clk, .rst, .cnt(cnt[c]), .loc(loc[c]), .blk_en(blk[c])
    );
  end

  assign wr_cnt    = cnt[0];
  assign rd_cnt    = cnt[1];
  assign wr_loc    = loc[0];
  assign rd_loc    = loc[1];
  assign wr_blk_en = blk[0];
  assign rd_blk_en = blk[1];

  // R4
  wr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    wr_full |=> $stable(wr_cnt));
  // R4
  rd_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    rd_empty |=> $stable(rd_cnt));
endmodule

// File: tb/fifo_addr_gen_bench.sv
`timescale 1ns/1ps
module fifo_addr_gen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic [2:0]  wid_mode = '0, cas_mode = '0;
  logic        wr_req = 0, wr_full = 0, rd_req = 0, rd_empty = 0;
  logic [15:0] wr_cnt, rd_cnt, wr_blk_en, rd_blk_en;
  logic [11:0] wr_loc, rd_loc;

  fifo_addr_gen u_fifo_addr_gen (
    .clk, .rst, .wid_mode, .cas_mode, .wr_req, .wr_full, .rd_req, .rd_empty,
    .wr_cnt, .rd_cnt, .wr_loc, .rd_loc, .wr_blk_en, .rd_blk_en
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct packed {
    logic [2:0]  wm;
    logic [2:0]  cm;
    logic [15:0] nw;
    logic [15:0] nr;
    logic [15:0] ew;
    logic [15:0] er;
  } vec_t;

  // steps: mode0=32, mode1=16, mode2=8, mode3=4, mode4=2, mode5=1
  localparam vec_t VECS [6] = '{
    '{3'd0, 3'd0, 16'd3,  16'd1, 16'h0060, 16'h0020},
    '{3'd5, 3'd0, 16'd5,  16'd2, 16'h0005, 16'h0002},
    '{3'd2, 3'd1, 16'd10, 16'd0, 16'h0050, 16'h0000},
    '{3'd3, 3'd2, 16'd7,  16'd3, 16'h001C, 16'h000C},
    '{3'd4, 3'd3, 16'd4,  16'd4, 16'h0008, 16'h0008},
    '{3'd1, 3'd4, 16'd2,  16'd1, 16'h0020, 16'h0010}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] wm, input logic [2:0] cm);
    rst = 1; wid_mode = wm; cas_mode = cm; wr_req = 0; rd_req = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic cyc(input logic w, input logic r);
    wr_req = w; rd_req = r;
    @(negedge clk);
    wr_req = 0; rd_req = 0;
  endtask

  task automatic run(input int nw, input int nr);
    for (int i = 0; i < ((nw > nr) ? nw : nr); i++) cyc(i < nw, i < nr);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(3'd0, 3'd0);
    // R1 reset state
    chk("R1 wr_cnt", wr_cnt, 16'h0000);
    chk("R1 rd_cnt", rd_cnt, 16'h0000);
    chk("R1 wr_blk_en", wr_blk_en, 16'h0001);
    chk("R1 rd_blk_en", rd_blk_en, 16'h0001);

    // R2 R3 R9: table walk, writes and reads overlap in the same cycles
    foreach (VECS[v]) begin
      do_reset(VECS[v].wm, VECS[v].cm);
      run(int'(VECS[v].nw), int'(VECS[v].nr));
      chk("R2 R9 wr step", wr_cnt, VECS[v].ew);
      chk("R3 R9 rd step", rd_cnt, VECS[v].er);
    end

    // R1: reset after activity clears
    rst = 1; @(negedge clk); rst = 0;
    chk("R1 wr clear", wr_cnt, 16'h0000);

    // R5 R6: no cascade, 36-bit words, wraps after 128 words
    do_reset(3'd0, 3'd0);
    run(127, 0);
    chk("R5 R6 no-cascade top", wr_cnt, 16'h0FE0);
    cyc(1, 0);
    chk("R5 no-cascade wrap", wr_cnt, 16'h0000);

    // R5 R8: two blocks, crossing into block 1
    do_reset(3'd0, 3'd1);
    run(128, 0);
    chk("R5 two-block carry", wr_cnt, 16'h1000);
    chk("R8 blk_en block1", wr_blk_en, 16'h0002);
    chk("R8 loc zero", {4'h0, wr_loc}, 16'h0000);
    run(128, 0);
    chk("R5 two-block wrap", wr_cnt, 16'h0000);

    // R5 R8: sixteen blocks, last word then wrap
    do_reset(3'd0, 3'd4);
    run(2047, 0);
    chk("R5 sixteen-block top", wr_cnt, 16'hFFE0);
    chk("R8 blk_en block15", wr_blk_en, 16'h8000);
    chk("R8 loc", {4'h0, wr_loc}, 16'h0FE0);
    cyc(1, 0);
    chk("R5 sixteen-block wrap", wr_cnt, 16'h0000);
    chk("R8 blk_en block0", wr_blk_en, 16'h0001);

    // R2 R5: out-of-range codes act as 1-bit words and 16 blocks
    do_reset(3'd7, 3'd6);
    run(3, 2);
    chk("R2 code7 step", wr_cnt, 16'h0003);
    chk("R3 code7 step", rd_cnt, 16'h0002);

    // R4: blocked accesses
    do_reset(3'd5, 3'd0);
    wr_full = 1; rd_empty = 1;
    run(3, 3);
    chk("R4 write blocked", wr_cnt, 16'h0000);
    chk("R4 read blocked", rd_cnt, 16'h0000);
    wr_full = 0; rd_empty = 0;
    run(1, 1);
    chk("R4 write resumes", wr_cnt, 16'h0001);
    chk("R4 read resumes", rd_cnt, 16'h0001);

    // R7: mode change without reset is ignored
    wid_mode = 3'd0; cas_mode = 3'd4;
    run(2, 0);
    chk("R7 old step kept", wr_cnt, 16'h0003);
    do_reset(3'd0, 3'd4);
    run(1, 0);
    chk("R7 new step after reset", wr_cnt, 16'h0020);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule